// File: doc/BRIEF.md
# Serial-Bus Status Pin Controller

This block drives one open-drain status pin that a host reads over a three-wire serial control bus. A 3-bit select field decides what the pin shows when the bus is idle. It can float, or pull low while the loop reports loss of lock. It can show a completion indicator for a frequency count. It can also mirror the level of one of two general-purpose I/O pins.

Bus activity has priority over the select field. While the chip enable is high in input-transfer mode, the pin floats. While the chip enable is high in output-transfer mode, the pin carries the read-data stream, and each new bit is taken on a falling edge of the serial clock.

The completion indicator is a single flag. A done strobe sets it. A rising edge of the count-enable bit clears it, and so does any bus transfer. When the flag is set and the completion mode is selected, the pin is pulled low, so the host can poll for the end of a count.

All inputs are sampled on `clk`. The pin state is registered, so every effect appears one clock after the edge that samples its cause.

Top module: `stat_pin_mux`

## Requirements
- R1: While reset is asserted and directly after it, `pin_sink` is 0 and `pin_level` is 1 (pin open), and the completion flag is clear.
- R2: With the bus idle (`bus_ce`=0), select codes 3'b000, 3'b011, 3'b100 and 3'b111 leave the pin open, whatever the other inputs are.
- R3: With the bus idle and select 3'b001, `pin_sink` equals the `unlock` input sampled one clock earlier.
- R4: A `cnt_done` pulse sets the completion flag unless a clear occurs in the same cycle. With the bus idle and select 3'b010, the pin sinks one clock after the flag is set.
- R5: A 0-to-1 transition of `cnt_en` clears the completion flag, and this clear wins over a simultaneous `cnt_done`. With select 3'b010 the pin goes open one clock later.
- R6: Any cycle with `bus_ce`=1 clears the completion flag, and this clear wins over `cnt_done`. After the transfer ends, select 3'b010 shows the pin open until the next done pulse.
- R7: With the bus idle, select 3'b101 makes the pin follow `gpio1_lvl` and select 3'b110 makes it follow `gpio2_lvl`. The pin sinks when the mirrored level is 0 and is open when it is 1.
- R8: With select 3'b101 and `gpio1_dir_out`=1, or select 3'b110 and `gpio2_dir_out`=1, the pin is open regardless of the level of that I/O pin.
- R9: With `bus_ce`=1 and `bus_rd_mode`=0 (input transfer), the pin is open for every select code and every status input.
- R10: With `bus_ce`=1 and `bus_rd_mode`=1 (output transfer), the pin shows a held read bit and ignores the select code. The held bit is loaded from `rd_bit` on the first clock of a transfer (`bus_ce` rising) and at each falling edge of `bus_sclk`, and it is held in between. The pin sinks when the held bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Serial bus chip enable; high marks a transfer |
| bus_sclk | input | 1 | Serial bus clock, oversampled by `clk` |
| bus_rd_mode | input | 1 | Transfer direction: 0 = input transfer, 1 = output (read) transfer |
| pin_sel | input | 3 | Status select code used while the bus is idle |
| cnt_en | input | 1 | Count-enable bit; a rising edge clears the completion flag |
| cnt_done | input | 1 | One-cycle strobe marking the end of a count measurement |
| unlock | input | 1 | Loss-of-lock flag |
| gpio1_lvl | input | 1 | Level of general I/O pin 1 |
| gpio2_lvl | input | 1 | Level of general I/O pin 2 |
| gpio1_dir_out | input | 1 | 1 when I/O pin 1 is configured as an output |
| gpio2_dir_out | input | 1 | 1 when I/O pin 2 is configured as an output |
| rd_bit | input | 1 | Current read-data bit from the bus shift register |
| pin_sink | output | 1 | Open-drain pull-down enable; 1 drives the pin low |
| pin_level | output | 1 | Resolved pin level with an external pull-up (inverse of `pin_sink`) |

## Verification
Every result of this block is due exactly one clock after the rising edge that samples its cause. This holds for a select change, a status level, a done strobe, a count-enable edge, a chip-enable change and a serial-clock fall.

The bench changes inputs only at falling edges of `clk`. It computes the expected pin state for that input set in the same step, then compares at the next falling edge, half a period after the register has updated.

Flag ordering is covered by directed sequences: a done pulse together with a start edge, a done pulse during a transfer, and the first read bit of a transfer. Random cycles mix all select codes with bus traffic.

// File: rtl/stat_pin_pkg.sv
package stat_pin_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF   = 3'd0,
    SEL_UNLK  = 3'd1,
    SEL_DONE  = 3'd2,
    SEL_RSV3  = 3'd3,
    SEL_RSV4  = 3'd4,
    SEL_GPIO1 = 3'd5,
    SEL_GPIO2 = 3'd6,
    SEL_RSV7  = 3'd7
  } pin_sel_e;

  // Sink decision for the idle-bus path: 1 means pull the pin low.
  function automatic logic idle_sink(
    input logic [SEL_W-1:0] sel,
    input logic unlk,
    input logic flag,
    input logic g1_lvl,
    input logic g2_lvl,
    input logic g1_out,
    input logic g2_out
  );
    logic s;
    unique case (pin_sel_e'(sel))
      SEL_UNLK:  s = unlk;
      SEL_DONE:  s = flag;
      SEL_GPIO1: s = !g1_out && !g1_lvl;
      SEL_GPIO2: s = !g2_out && !g2_lvl;
      default:   s = 1'b0;
    endcase
    return s;
  endfunction

  // Bus override: input transfer floats, output transfer sinks on a 0 bit.
  function automatic logic bus_sink(input logic rd_mode, input logic held_bit);
    return rd_mode && !held_bit;
  endfunction

endpackage

// File: rtl/sp_edge.sv
module sp_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] d_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q[i] <= 1'b0;
      else        d_q[i] <= d[i];
    end
    assign rise[i] = d[i] && !d_q[i];
    assign fall[i] = !d[i] && d_q[i];
  end

endmodule

// File: rtl/sp_done_flag.sv
module sp_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_nxt,
  output logic flag
);

  // clear has priority over set
  assign flag_nxt = clr_i ? 1'b0 : (flag || set_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nxt;
  end

  // R6
  flag_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag);

endmodule

// File: rtl/sp_rd_hold.sv
module sp_rd_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic d_i,
  output logic q_nxt,
  output logic q
);

  assign q_nxt = load_i ? d_i : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b1;
    else        q <= q_nxt;
  end

  // R10
  rd_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q));

endmodule

// File: rtl/stat_pin_mux.sv
module stat_pin_mux
  import stat_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_ce,
  input  logic             bus_sclk,
  input  logic             bus_rd_mode,
  input  logic [SEL_W-1:0] pin_sel,
  input  logic             cnt_en,
  input  logic             cnt_done,
  input  logic             unlock,
  input  logic             gpio1_lvl,
  input  logic             gpio2_lvl,
  input  logic             gpio1_dir_out,
  input  logic             gpio2_dir_out,
  input  logic             rd_bit,
  output logic             pin_sink,
  output logic             pin_level
);

  localparam int EDGE_N  = 3;
  localparam int IDX_CE  = 0;
  localparam int IDX_EN  = 1;
  localparam int IDX_SCK = 2;

  logic [EDGE_N-1:0] ev_rise, ev_fall;

  sp_edge #(.W(EDGE_N)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bus_sclk, cnt_en, bus_ce}),
    .rise (ev_rise),
    .fall (ev_fall)
  );

  // named internal events
  logic ce_start, cnt_start, sclk_fall, xfer_in, xfer_out;
  assign ce_start  = ev_rise[IDX_CE];
  assign cnt_start = ev_rise[IDX_EN];
  assign sclk_fall = ev_fall[IDX_SCK];
  assign xfer_in   = bus_ce && !bus_rd_mode;
  assign xfer_out  = bus_ce && bus_rd_mode;

  logic flag_nxt, flag_q;
  sp_done_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (cnt_done),
    .clr_i   (bus_ce || cnt_start),
    .flag_nxt(flag_nxt),
    .flag    (flag_q)
  );

  logic rd_load, rd_nxt, rd_q;
  assign rd_load = xfer_out && (ce_start || sclk_fall);

  sp_rd_hold u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(rd_load),
    .d_i   (rd_bit),
    .q_nxt (rd_nxt),
    .q     (rd_q)
  );

  logic sink_idle, sink_nxt;
  assign sink_idle = idle_sink(pin_sel, unlock, flag_nxt, gpio1_lvl, gpio2_lvl,
                               gpio1_dir_out, gpio2_dir_out);
  assign sink_nxt  = bus_ce ? bus_sink(bus_rd_mode, rd_nxt) : sink_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sink <= 1'b0;
    else        pin_sink <= sink_nxt;
  end

  assign pin_level = !pin_sink;

  // R9
  input_xfer_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_in |=> !pin_sink);

  // R10
  read_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_out && sclk_fall) |=> (pin_sink == !$past(rd_bit)));

  // R8
  gpio_out_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce && pin_sel == SEL_GPIO1 && gpio1_dir_out) |=> !pin_sink);

  // R3
  unlock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce && pin_sel == SEL_UNLK) |=> (pin_sink == $past(unlock)));

  // R5
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce && pin_sel == SEL_DONE && cnt_start) |=> !pin_sink);

endmodule

// File: tb/sim_stat_pin_mux.sv
module sim_stat_pin_mux;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce = 0, bus_sclk = 0, bus_rd_mode = 0;
  logic [2:0] pin_sel = 3'd0;
  logic cnt_en = 0, cnt_done = 0, unlock = 0;
  logic gpio1_lvl = 0, gpio2_lvl = 0, gpio1_dir_out = 0, gpio2_dir_out = 0;
  logic rd_bit = 0;
  logic pin_sink, pin_level;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = !clk;

  stat_pin_mux u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_sclk(bus_sclk),
    .bus_rd_mode(bus_rd_mode), .pin_sel(pin_sel), .cnt_en(cnt_en),
    .cnt_done(cnt_done), .unlock(unlock), .gpio1_lvl(gpio1_lvl),
    .gpio2_lvl(gpio2_lvl), .gpio1_dir_out(gpio1_dir_out),
    .gpio2_dir_out(gpio2_dir_out), .rd_bit(rd_bit),
    .pin_sink(pin_sink), .pin_level(pin_level)
  );

  // bench model state
  bit m_ce, m_en, m_sc, m_flag, m_rd;

  function automatic bit pin_low_for(input bit [2:0] s, input bit flag);
    case (s)
      3'b001: return unlock;
      3'b010: return flag;
      3'b101: return gpio1_dir_out ? 1'b0 : !gpio1_lvl;
      3'b110: return gpio2_dir_out ? 1'b0 : !gpio2_lvl;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_for(input bit [2:0] s);
    if (bus_ce) return bus_rd_mode ? "R10" : "R9";
    case (s)
      3'b001: return "R3";
      3'b010: return "R4";
      3'b101: return gpio1_dir_out ? "R8" : "R7";
      3'b110: return gpio2_dir_out ? "R8" : "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pin_sink actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge with inputs already set
  task automatic step(input string tag);
    bit ce_up, en_up, sc_dn, exp;
    string t;
    ce_up = bus_ce && !m_ce;
    en_up = cnt_en && !m_en;
    sc_dn = !bus_sclk && m_sc;
    if (bus_ce || en_up) m_flag = 0;
    else if (cnt_done)   m_flag = 1;
    if (bus_ce && bus_rd_mode && (ce_up || sc_dn)) m_rd = rd_bit;
    if (bus_ce) exp = bus_rd_mode ? !m_rd : 1'b0;
    else        exp = pin_low_for(pin_sel, m_flag);
    t = (tag == "") ? tag_for(pin_sel) : tag;
    m_ce = bus_ce; m_en = cnt_en; m_sc = bus_sclk;
    @(posedge clk);
    @(negedge clk);
    check(t, pin_sink, exp);
    checks++;
    if (pin_level !== !pin_sink) begin
      errors++;
      $display("FAIL %s: pin_level actual=%0b expected=%0b", t, pin_level, !pin_sink);
    end
  endtask

  task automatic idle_all();
    bus_ce = 0; cnt_done = 0; cnt_en = 0; bus_sclk = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    pin_sel = 3'b010; cnt_done = 1; unlock = 1;
    repeat (3) @(negedge clk);
    check("R1", pin_sink, 1'b0);
    check("R1", pin_level, 1'b1);
    cnt_done = 0; pin_sel = 3'b000; unlock = 0;
    rst_n = 1;
    m_ce = 0; m_en = 0; m_sc = 0; m_flag = 0; m_rd = 1;
    step("R1");
    pin_sel = 3'b010; step("R1");   // flag clear after reset

    // R4 / R5: completion sequence
    cnt_en = 1; step("R5");
    cnt_done = 1; step("R4");
    cnt_done = 0; step("R4");
    cnt_en = 0; step("R4");
    cnt_en = 1; cnt_done = 1; step("R5"); // start edge beats done
    cnt_done = 0; step("R5");
    cnt_done = 1; step("R4");
    cnt_done = 0;
    // R6: transfer clears flag, even with done present
    bus_ce = 1; bus_rd_mode = 0; cnt_done = 1; step("R6");
    bus_ce = 0; cnt_done = 0; step("R6");
    step("R6");

    // R7 / R8
    pin_sel = 3'b101; gpio1_lvl = 0; step("R7");
    gpio1_lvl = 1; step("R7");
    gpio1_lvl = 0; gpio1_dir_out = 1; step("R8");
    pin_sel = 3'b110; gpio2_lvl = 0; gpio2_dir_out = 1; step("R8");
    gpio2_dir_out = 0; step("R7");
    gpio1_dir_out = 0;

    // R3 / R2
    pin_sel = 3'b001; unlock = 1; step("R3");
    unlock = 0; step("R3");
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 3 || c == 4 || c == 7) begin
        pin_sel = 3'(c); unlock = 1; step("R2");
      end
    end
    unlock = 0;

    // R10: read stream, first bit at ce rise, then sclk falls
    pin_sel = 3'b010; bus_rd_mode = 1; bus_sclk = 0;
    rd_bit = 0; bus_ce = 1; step("R10");
    rd_bit = 1; step("R10");           // held, no edge
    bus_sclk = 1; step("R10");
    bus_sclk = 0; step("R10");         // load 1
    rd_bit = 0; bus_sclk = 1; step("R10");
    bus_sclk = 0; step("R10");         // load 0
    // R9: input transfer floats for every select
    bus_rd_mode = 0;
    for (int c = 0; c < 8; c++) begin
      pin_sel = 3'(c); unlock = 1; step("R9");
    end
    idle_all(); unlock = 0; step("");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      pin_sel       = 3'($urandom_range(0, 7));
      bus_ce        = ($urandom_range(0, 3) == 0);
      bus_rd_mode   = 1'($urandom_range(0, 1));
      bus_sclk      = bus_ce ? !bus_sclk : 1'b0;
      cnt_en        = ($urandom_range(0, 5) == 0) ? !cnt_en : cnt_en;
      cnt_done      = ($urandom_range(0, 7) == 0);
      unlock        = 1'($urandom_range(0, 1));
      gpio1_lvl     = 1'($urandom_range(0, 1));
      gpio2_lvl     = 1'($urandom_range(0, 1));
      gpio1_dir_out = ($urandom_range(0, 3) == 0);
      gpio2_dir_out = ($urandom_range(0, 3) == 0);
      rd_bit        = 1'($urandom_range(0, 1));
      step("");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all R): actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule